// File: doc/BRIEF.md
# Page Access-Control Checker

This block sits beside the address translation path of a memory management unit. It checks every memory access against the access-control code of the target page. The code is a 3-bit field held in that page's descriptor. In the same cycle as the access strobe, the block decides whether the access is aborted, trapped, or simply allowed. It keeps one descriptor register per page and loads it from a software write port. Any descriptor can be read back combinationally on a separate read port.

Each descriptor carries a sticky attention bit at bit 7, used to gather memory-management statistics. The block sets this bit only when the access is not aborted and the page's code asks for a trap on that kind of access. Accesses that complete without a trap leave the bit alone. Only a software write to the descriptor clears it.

The access-control code sits in descriptor bits 2:0, and the attention bit sits in bit 7. All other descriptor bits are stored and read back unchanged.

Top module: `mmu_acf_check`

## Requirements
- R1: After reset every descriptor reads back as zero, so every access to any page aborts and none traps.
- R2: With access-control code 0, 3 or 7, every read and every write aborts and never traps.
- R3: With code 1 or code 2 the page is read-only: a write aborts. A read with code 1 traps. A read with code 2 completes with no trap.
- R4: With code 4, both reads and writes trap and neither aborts.
- R5: With code 5, a write traps and a read completes with no trap. Neither aborts.
- R6: With code 6, reads and writes complete with neither abort nor trap.
- R7: A trapping access sets bit 7 of the accessed page's descriptor. The new value is visible on the read port from the cycle after the strobe.
- R8: An access that does not trap leaves bit 7 unchanged. This includes aborted accesses and accesses that complete normally.
- R9: Abort and trap are combinational, in the same cycle as the access strobe. They are both low when no strobe is present. Abort takes priority, so abort and trap are never high together. Trap lasts only as long as the strobe, one cycle per access.
- R10: A descriptor write stores the written data with bit 7 forced to zero. If a trapping access to the same page occurs in the same cycle, the write wins and bit 7 stays zero.
- R11: Once set, bit 7 stays set through any number of later accesses until software writes that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| acc_page | input | PW | Page index of the access |
| acc_abort | output | 1 | Access aborted |
| acc_trap | output | 1 | Access meets its trap condition |
| dw_en | input | 1 | Software descriptor write enable |
| dw_page | input | PW | Page index of the descriptor write |
| dw_data | input | 16 | Descriptor value to store |
| rd_page | input | PW | Page index for read-back |
| rd_data | output | 16 | Descriptor of page rd_page, including bit 7 |

## Verification
The bench builds the block with its default of 16 pages. This lets it place different access-control codes on distinct pages at once. It can then show that setting or clearing bit 7 on one page leaves the others untouched, and it can exercise the highest page index. A page count that is a power of two also keeps every page index valid. With that width, the same-cycle collision between a descriptor write and a trapping access can be driven on both the lowest and the highest page.

// File: rtl/mmu_acf_pkg.sv
package mmu_acf_pkg;

    localparam int DESC_W   = 16;
    localparam int ATTN_BIT = 7;
    localparam int CODE_W   = 3;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONRES0 = 3'd0,
        CODE_RO_TRAP = 3'd1,
        CODE_RO      = 3'd2,
        CODE_RSVD3   = 3'd3,
        CODE_RW_TRAP = 3'd4,
        CODE_RW_WTRP = 3'd5,
        CODE_RW      = 3'd6,
        CODE_RSVD7   = 3'd7
    } acc_code_t;

    typedef struct packed {
        logic abort;
        logic trap;
    } verdict_t;

    function automatic acc_code_t code_of(input logic [DESC_W-1:0] d);
        return acc_code_t'(d[CODE_W-1:0]);
    endfunction

    function automatic verdict_t classify(input acc_code_t c, input logic is_wr);
        verdict_t v;
        v = '{abort: 1'b0, trap: 1'b0};
        case (c)
            CODE_RO_TRAP: begin
                v.abort = is_wr;
                v.trap  = ~is_wr;
            end
            CODE_RO:      v.abort = is_wr;
            CODE_RW_TRAP: v.trap  = 1'b1;
            CODE_RW_WTRP: v.trap  = is_wr;
            CODE_RW:      v = '{abort: 1'b0, trap: 1'b0};
            default:      v.abort = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mmu_acf_decide.sv
module mmu_acf_decide
    import mmu_acf_pkg::*;
(
    input  logic      valid,
    input  logic      is_write,
    input  acc_code_t code,
    output logic      abort,
    output logic      trap,
    output logic      mark
);
    verdict_t raw;

    always_comb begin
        raw   = classify(code, is_write);
        abort = valid & raw.abort;
        trap  = valid & ~raw.abort & raw.trap;
        mark  = trap;
    end
endmodule

// File: rtl/mmu_desc_bank.sv
module mmu_desc_bank
    import mmu_acf_pkg::*;
#(
    parameter int PAGES = 16,
    parameter int PW    = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_page,
    input  logic [DESC_W-1:0] wr_data,
    input  logic              mark_en,
    input  logic [PW-1:0]     mark_page,
    input  logic [PW-1:0]     look_page,
    output logic [DESC_W-1:0] look_desc,
    input  logic [PW-1:0]     rd_page,
    output logic [DESC_W-1:0] rd_desc,
    output logic [PAGES-1:0]  attn
);
    localparam logic [DESC_W-1:0] ATTN_MASK = DESC_W'(1) << ATTN_BIT;

    logic [DESC_W-1:0] desc_q [PAGES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGES; i++) begin
            if (rst) begin
                desc_q[i] <= '0;
            end else if (wr_en && wr_page == PW'(i)) begin
                desc_q[i] <= wr_data & ~ATTN_MASK;
            end else if (mark_en && mark_page == PW'(i)) begin
                desc_q[i] <= desc_q[i] | ATTN_MASK;
            end
        end
    end

    assign look_desc = desc_q[look_page];
    assign rd_desc   = desc_q[rd_page];

    for (genvar g = 0; g < PAGES; g++) begin : g_attn
        assign attn[g] = desc_q[g][ATTN_BIT];
    end
endmodule

// File: rtl/mmu_acf_check.sv
module mmu_acf_check
    import mmu_acf_pkg::*;
#(
    parameter int PAGES = 16,
    localparam int PW   = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [PW-1:0]     acc_page,
    output logic              acc_abort,
    output logic              acc_trap,
    input  logic              dw_en,
    input  logic [PW-1:0]     dw_page,
    input  logic [DESC_W-1:0] dw_data,
    input  logic [PW-1:0]     rd_page,
    output logic [DESC_W-1:0] rd_data
);
    logic [DESC_W-1:0] cur_desc;
    acc_code_t         cur_code;
    logic [CODE_W-1:0] cur_code_bits;
    logic              mark;
    logic [PAGES-1:0]  attn;

    assign cur_code      = code_of(cur_desc);
    assign cur_code_bits = cur_desc[CODE_W-1:0];

    mmu_acf_decide u_decide (
        .valid    (acc_valid),
        .is_write (acc_write),
        .code     (cur_code),
        .abort    (acc_abort),
        .trap     (acc_trap),
        .mark     (mark)
    );

    mmu_desc_bank #(.PAGES(PAGES), .PW(PW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (dw_en),
        .wr_page   (dw_page),
        .wr_data   (dw_data),
        .mark_en   (mark),
        .mark_page (acc_page),
        .look_page (acc_page),
        .look_desc (cur_desc),
        .rd_page   (rd_page),
        .rd_desc   (rd_data),
        .attn      (attn)
    );
endmodule

// File: rtl/mmu_acf_check_sva.sv
module mmu_acf_check_sva #(
    parameter int PAGES = 16,
    parameter int PW    = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic [PW-1:0]    acc_page,
    input logic             acc_abort,
    input logic             acc_trap,
    input logic             dw_en,
    input logic [PW-1:0]    dw_page,
    input logic [2:0]       code,
    input logic [PAGES-1:0] attn
);
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (!acc_abort && !acc_trap));

    assert_abort_wins_R9: assert property (@(posedge clk) disable iff (rst)
        acc_abort |-> !acc_trap);

    assert_code4_traps_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && code == 3'd4) |-> (acc_trap && !acc_abort));

    assert_nonres_abort_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (code == 3'd0 || code == 3'd3 || code == 3'd7))
            |-> (acc_abort && !acc_trap));

    assert_trap_marks_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_trap && !(dw_en && dw_page == acc_page)) |=> attn[$past(acc_page)]);

    assert_write_clears_R10: assert property (@(posedge clk) disable iff (rst)
        dw_en |=> !attn[$past(dw_page)]);

    assert_no_trap_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (!acc_trap && !dw_en) |=> (attn == $past(attn)));

    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        !dw_en |=> (($past(attn) & ~attn) == '0));
endmodule

bind mmu_acf_check mmu_acf_check_sva #(.PAGES(PAGES), .PW(PW)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_page  (acc_page),
    .acc_abort (acc_abort),
    .acc_trap  (acc_trap),
    .dw_en     (dw_en),
    .dw_page   (dw_page),
    .code      (cur_code_bits),
    .attn      (attn)
);

// File: tb/test_mmu_acf_check.sv
`timescale 1ns/1ps
module test_mmu_acf_check;
    localparam int PAGES = 16;
    localparam int PW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [PW-1:0] acc_page  = '0;
    logic          acc_abort;
    logic          acc_trap;
    logic          dw_en = 1'b0;
    logic [PW-1:0] dw_page = '0;
    logic [15:0]   dw_data = '0;
    logic [PW-1:0] rd_page = '0;
    logic [15:0]   rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mmu_acf_check #(.PAGES(PAGES)) i_mmu_acf_check (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_page(acc_page),
        .acc_abort(acc_abort), .acc_trap(acc_trap),
        .dw_en(dw_en), .dw_page(dw_page), .dw_data(dw_data),
        .rd_page(rd_page), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] desc_val(input logic [2:0] code);
        return {8'h5A, 1'b1, 4'b0110, code};
    endfunction

    task automatic load(input logic [PW-1:0] pg, input logic [2:0] code);
        @(negedge clk);
        dw_en = 1'b1; dw_page = pg; dw_data = desc_val(code);
        @(negedge clk);
        dw_en = 1'b0;
    endtask

    task automatic read_attn(input string req, input logic [PW-1:0] pg, input logic exp);
        rd_page = pg;
        #1;
        chk(req, {15'b0, rd_data[7]}, {15'b0, exp});
    endtask

    task automatic access(input string req, input logic [PW-1:0] pg, input logic wr,
                          input logic ex_abort, input logic ex_trap);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_page = pg;
        #1;
        chk({req, " abort"}, {15'b0, acc_abort}, {15'b0, ex_abort});
        chk({req, " trap"},  {15'b0, acc_trap},  {15'b0, ex_trap});
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
        chk("R9 trap ends with strobe", {14'b0, acc_trap, acc_abort}, 16'h0000);
    endtask

    task automatic t_reset;
        read_attn("R1 reset attn", 4'd0, 1'b0);
        rd_page = 4'd9; #1;
        chk("R1 reset descriptor", rd_data, 16'h0000);
        access("R1 reset access", 4'd3, 1'b0, 1'b1, 1'b0);
        access("R1 reset write", 4'd15, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_abort_codes;
        load(4'd0, 3'd0); load(4'd3, 3'd3); load(4'd7, 3'd7);
        access("R2 code0 rd", 4'd0, 1'b0, 1'b1, 1'b0);
        access("R2 code3 wr", 4'd3, 1'b1, 1'b1, 1'b0);
        access("R2 code7 rd", 4'd7, 1'b0, 1'b1, 1'b0);
        access("R2 code7 wr", 4'd7, 1'b1, 1'b1, 1'b0);
        read_attn("R8 aborted leaves attn", 4'd7, 1'b0);
        rd_page = 4'd3; #1;
        chk("R10 stored value", rd_data, desc_val(3'd3) & ~16'h0080);
    endtask

    task automatic t_readonly;
        load(4'd1, 3'd1); load(4'd2, 3'd2);
        access("R3 code1 wr", 4'd1, 1'b1, 1'b1, 1'b0);
        read_attn("R8 aborted write", 4'd1, 1'b0);
        access("R3 code1 rd", 4'd1, 1'b0, 1'b0, 1'b1);
        read_attn("R7 code1 read sets attn", 4'd1, 1'b1);
        access("R3 code2 rd", 4'd2, 1'b0, 1'b0, 1'b0);
        access("R3 code2 wr", 4'd2, 1'b1, 1'b1, 1'b0);
        read_attn("R8 code2 attn clear", 4'd2, 1'b0);
    endtask

    task automatic t_code4;
        load(4'd4, 3'd4); load(4'd8, 3'd4);
        access("R4 code4 rd", 4'd4, 1'b0, 1'b0, 1'b1);
        read_attn("R7 code4 read sets", 4'd4, 1'b1);
        access("R4 code4 wr", 4'd8, 1'b1, 1'b0, 1'b1);
        read_attn("R7 code4 write sets", 4'd8, 1'b1);
        read_attn("R8 other page untouched", 4'd2, 1'b0);
    endtask

    task automatic t_code5_6;
        load(4'd5, 3'd5); load(4'd6, 3'd6);
        access("R5 code5 rd", 4'd5, 1'b0, 1'b0, 1'b0);
        read_attn("R8 code5 read no attn", 4'd5, 1'b0);
        access("R5 code5 wr", 4'd5, 1'b1, 1'b0, 1'b1);
        read_attn("R7 code5 write sets", 4'd5, 1'b1);
        access("R6 code6 rd", 4'd6, 1'b0, 1'b0, 1'b0);
        access("R6 code6 wr", 4'd6, 1'b1, 1'b0, 1'b0);
        read_attn("R8 code6 no attn", 4'd6, 1'b0);
    endtask

    task automatic t_sticky;
        access("R11 code5 rd after set", 4'd5, 1'b0, 1'b0, 1'b0);
        access("R11 code5 wr again", 4'd5, 1'b1, 1'b0, 1'b1);
        read_attn("R11 attn stays", 4'd5, 1'b1);
        load(4'd5, 3'd5);
        read_attn("R10 write clears attn", 4'd5, 1'b0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b1; acc_page = 4'd4;
        #1;
        chk("R9 no strobe quiet", {14'b0, acc_trap, acc_abort}, 16'h0000);
    endtask

    task automatic t_collide(input logic [PW-1:0] pg);
        load(pg, 3'd4);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_page = pg;
        dw_en = 1'b1; dw_page = pg; dw_data = desc_val(3'd4);
        #1;
        chk("R10 collide trap", {15'b0, acc_trap}, 16'h0001);
        @(negedge clk);
        acc_valid = 1'b0; dw_en = 1'b0;
        read_attn("R10 write wins collision", pg, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_abort_codes();
        t_readonly();
        t_code4();
        t_code5_6();
        t_sticky();
        t_idle();
        t_collide(4'd0);
        t_collide(4'd15);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule